// File: doc/BRIEF.md
# USB Endpoint Status and Setup Interlock

This block sits inside a full-speed USB device controller. It stands between the local microcontroller and the serial engine that completes transactions. For each of sixteen endpoints it keeps a one-byte record of the most recent transaction. The firmware fetches that record with a per-endpoint read command. The block also keeps a sticky flag that tells the firmware when a newer event replaced a record it had not yet read.

The block also runs the control-endpoint SETUP interlock. When a SETUP packet arrives, buffer validate and clear commands aimed at either control endpoint are suppressed until the firmware sends an acknowledge command. A second SETUP that arrives before the first was acknowledged or stalled raises an overwrite flag. The firmware can read this flag, and the read clears it only after the engine reports that the new setup data has been completely written.

The microcontroller writes one command byte per cycle with `cmd_valid`. A read command answers on the following cycle with a single `rd_valid` pulse and the byte on `rd_data`. Buffer commands appear as one-cycle pulses on `buf_validate` or `buf_clear`, and the targeted endpoint is shown on `buf_ep`.

Top module: `usbep_status_top`

## Requirements
- R1: After reset, every endpoint status byte reads 0x00, the endpoint selection is 0, the lockout is clear, the overwrite flag is clear, and `rd_valid`, `buf_validate` and `buf_clear` are 0.
- R2: Command 0xA0+n (n = 0..15) gives exactly one `rd_valid` pulse on the cycle after the command, with endpoint n's status byte on `rd_data`. The byte layout is: bit 7 unread, bit 6 data toggle, bit 5 zero, bits 4:1 error code, bit 0 transfer-ok. Index 0 is control OUT, index 1 is control IN, and indexes 2..15 are endpoints 1..14.
- R3: A transaction event on endpoint n replaces its error code and sets its transfer-ok bit to the event's success input. The data toggle bit takes the event's PID (1 = DATA1) only when the event reports success; otherwise it keeps its old value.
- R4: An event recorded while the endpoint's previous record is still unread sets the unread bit. A status read clears the unread bit and the transfer-ok bit of that endpoint, on the same edge that presents the byte.
- R5: When an event and a status read hit the same endpoint in the same cycle, the read presents the old byte. The event's fields are stored, and the unread bit ends up set if the previous record had not been read before that cycle.
- R6: A SETUP pulse sets the lockout (`setup_locked` = 1 on the next cycle). While the lockout is set, validate (0xFA) and clear (0xF2) commands produce no pulse when the selected endpoint is 0 or 1. The same commands on other endpoints still pulse.
- R7: Acknowledge (0xF4) clears the lockout on the next cycle and produces no `rd_valid` pulse. A SETUP in the same cycle as the acknowledge wins.
- R8: A SETUP that arrives while an earlier SETUP has been neither acknowledged nor stalled (`ctl_stall` pulse) sets the overwrite flag.
- R9: Command 0xD0 reads the setup flags byte: bit 3 is overwrite, bit 0 is lockout, and the other bits are 0. The read clears the overwrite flag only if a `setup_done` pulse has come since the last SETUP, or comes in the same cycle as the read.
- R10: Any command byte outside 0x00..0x0F, 0xA0..0xAF, 0xD0, 0xF2, 0xF4 and 0xFA is ignored. It produces no output pulse and changes no state.
- R11: Commands 0x00+n select endpoint n as the target of later validate and clear commands. `buf_ep` shows the selection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command byte strobe from microcontroller |
| cmd_byte | input | 8 | Command code |
| rd_valid | output | 1 | Read data valid, one cycle per read command |
| rd_data | output | 8 | Read data byte |
| evt_valid | input | 1 | Transaction completed |
| evt_ep | input | 4 | Endpoint index of the completed transaction |
| evt_err | input | 4 | Error code of the transaction |
| evt_ok | input | 1 | Transaction succeeded |
| evt_pid1 | input | 1 | Data PID of the packet was DATA1 |
| setup_rx | input | 1 | SETUP packet received pulse |
| setup_done | input | 1 | Setup data fully written pulse |
| ctl_stall | input | 1 | Control endpoint stalled pulse |
| buf_validate | output | 1 | Validate-buffer pulse |
| buf_clear | output | 1 | Clear-buffer pulse |
| buf_ep | output | 4 | Selected endpoint for buffer commands |
| setup_locked | output | 1 | Lockout active |

## Verification
The bench first reads records straight after reset. It then checks that a failed event leaves the toggle bit alone, because a design that always copies the PID would report DATA1 after an errored packet. The bench also collides an event with a read of the same endpoint. A design that lets the read win would lose the unread bit or present the new byte early. On the interlock side the bench checks that both control endpoints are blocked and that endpoint 1 of the data endpoints is not. It also checks that a stall between two SETUPs suppresses the overwrite flag. Finally it checks that reading the overwrite flag while the setup write is still busy keeps the flag, where a design that clears on every read would drop it.

// File: rtl/usbep_pkg.sv
package usbep_pkg;

    localparam int EP_MAX    = 16;
    localparam int EP_IDXW   = $clog2(EP_MAX);
    localparam int CTRL_EPS  = 2;
    localparam int ERRW      = 4;

    localparam logic [3:0] OPH_SELECT = 4'h0;
    localparam logic [3:0] OPH_RDSTAT = 4'hA;
    localparam logic [7:0] OP_ACK     = 8'hF4;
    localparam logic [7:0] OP_VALID   = 8'hFA;
    localparam logic [7:0] OP_CLEAR   = 8'hF2;
    localparam logic [7:0] OP_RDSETUP = 8'hD0;

    typedef enum logic [2:0] {
        CK_NONE,
        CK_SELECT,
        CK_RDSTAT,
        CK_ACK,
        CK_VALIDATE,
        CK_CLEAR,
        CK_RDSETUP
    } cmd_kind_e;

    typedef struct packed {
        cmd_kind_e            kind;
        logic [EP_IDXW-1:0]   ep;
    } cmd_t;

    typedef struct packed {
        logic            unread;
        logic            data01;
        logic [ERRW-1:0] err;
        logic            rtok;
    } ep_stat_t;

    function automatic logic [7:0] stat_to_byte(ep_stat_t s);
        return {s.unread, s.data01, 1'b0, s.err, s.rtok};
    endfunction

    function automatic logic [7:0] setup_to_byte(logic ovwr, logic lock);
        return {4'b0000, ovwr, 2'b00, lock};
    endfunction

endpackage

// File: rtl/usbep_cmd_dec.sv
module usbep_cmd_dec
    import usbep_pkg::*;
#(
    parameter int NUM_EP = EP_MAX
) (
    input  logic       valid_i,
    input  logic [7:0] byte_i,
    output cmd_t       cmd_o
);

    logic ep_in_range;

    always_comb begin
        ep_in_range = int'(byte_i[3:0]) < NUM_EP;
        cmd_o.kind  = CK_NONE;
        cmd_o.ep    = byte_i[EP_IDXW-1:0];
        if (valid_i) begin
            if (byte_i[7:4] == OPH_RDSTAT && ep_in_range) begin
                cmd_o.kind = CK_RDSTAT;
            end else if (byte_i[7:4] == OPH_SELECT && ep_in_range) begin
                cmd_o.kind = CK_SELECT;
            end else begin
                case (byte_i)
                    OP_ACK:     cmd_o.kind = CK_ACK;
                    OP_VALID:   cmd_o.kind = CK_VALIDATE;
                    OP_CLEAR:   cmd_o.kind = CK_CLEAR;
                    OP_RDSETUP: cmd_o.kind = CK_RDSETUP;
                    default:    cmd_o.kind = CK_NONE;
                endcase
            end
        end
    end

endmodule

// File: rtl/usbep_stat_file.sv
module usbep_stat_file
    import usbep_pkg::*;
#(
    parameter int NUM_EP = EP_MAX
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               evt_valid_i,
    input  logic [EP_IDXW-1:0] evt_ep_i,
    input  logic [ERRW-1:0]    evt_err_i,
    input  logic               evt_ok_i,
    input  logic               evt_pid1_i,
    input  logic               rd_hit_i,
    input  logic [EP_IDXW-1:0] rd_ep_i,
    output ep_stat_t           stat_o [NUM_EP]
);

    for (genvar g = 0; g < NUM_EP; g++) begin : g_ep
        ep_stat_t stat_q;
        logic     fresh_q;
        logic     evt_here;
        logic     rd_here;

        assign evt_here = evt_valid_i && (evt_ep_i == EP_IDXW'(g));
        assign rd_here  = rd_hit_i && (rd_ep_i == EP_IDXW'(g));

        always_ff @(posedge clk) begin
            if (rst) begin
                stat_q  <= '0;
                fresh_q <= 1'b0;
            end else if (evt_here) begin
                stat_q.unread <= stat_q.unread | fresh_q;
                stat_q.err    <= evt_err_i;
                stat_q.rtok   <= evt_ok_i;
                if (evt_ok_i) begin
                    stat_q.data01 <= evt_pid1_i;
                end
                fresh_q <= 1'b1;
            end else if (rd_here) begin
                stat_q.unread <= 1'b0;
                stat_q.rtok   <= 1'b0;
                fresh_q       <= 1'b0;
            end
        end

        assign stat_o[g] = stat_q;

        AST_RD_CLEARS: assert property (@(posedge clk) disable iff (rst)
            rd_here && !evt_here |=> !stat_q.unread && !stat_q.rtok); // R4
        AST_EVT_WINS: assert property (@(posedge clk) disable iff (rst)
            evt_here && rd_here && fresh_q |=> stat_q.unread); // R5
        AST_TOGGLE_HOLD: assert property (@(posedge clk) disable iff (rst)
            evt_here && !evt_ok_i |=> stat_q.data01 == $past(stat_q.data01)); // R3
    end

endmodule

// File: rtl/usbep_setup_lock.sv
module usbep_setup_lock (
    input  logic clk,
    input  logic rst,
    input  logic setup_rx_i,
    input  logic setup_done_i,
    input  logic stall_i,
    input  logic ack_i,
    input  logic flag_rd_i,
    output logic lock_o,
    output logic ovwr_o
);

    logic lock_q;
    logic pend_q;
    logic busy_q;
    logic ovwr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            lock_q <= 1'b0;
            pend_q <= 1'b0;
            busy_q <= 1'b0;
            ovwr_q <= 1'b0;
        end else begin
            if (setup_rx_i) begin
                lock_q <= 1'b1;
                pend_q <= 1'b1;
                busy_q <= 1'b1;
            end else begin
                if (ack_i) lock_q <= 1'b0;
                if (ack_i || stall_i) pend_q <= 1'b0;
                if (setup_done_i) busy_q <= 1'b0;
            end

            if (setup_rx_i && pend_q) begin
                ovwr_q <= 1'b1;
            end else if (flag_rd_i && (!busy_q || setup_done_i)) begin
                ovwr_q <= 1'b0;
            end
        end
    end

    assign lock_o = lock_q;
    assign ovwr_o = ovwr_q;

    AST_SETUP_LOCKS: assert property (@(posedge clk) disable iff (rst)
        setup_rx_i |=> lock_q); // R6
    AST_ACK_UNLOCKS: assert property (@(posedge clk) disable iff (rst)
        ack_i && !setup_rx_i |=> !lock_q); // R7
    AST_OVWR_SET: assert property (@(posedge clk) disable iff (rst)
        setup_rx_i && pend_q |=> ovwr_q); // R8
    AST_OVWR_KEEP_BUSY: assert property (@(posedge clk) disable iff (rst)
        ovwr_q && busy_q && !setup_done_i |=> ovwr_q); // R9

endmodule

// File: rtl/usbep_status_top.sv
module usbep_status_top
    import usbep_pkg::*;
#(
    parameter int NUM_EP = EP_MAX
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cmd_valid,
    input  logic [7:0] cmd_byte,
    output logic       rd_valid,
    output logic [7:0] rd_data,
    input  logic       evt_valid,
    input  logic [3:0] evt_ep,
    input  logic [3:0] evt_err,
    input  logic       evt_ok,
    input  logic       evt_pid1,
    input  logic       setup_rx,
    input  logic       setup_done,
    input  logic       ctl_stall,
    output logic       buf_validate,
    output logic       buf_clear,
    output logic [3:0] buf_ep,
    output logic       setup_locked
);

    cmd_t               cmd;
    ep_stat_t           stat_w [NUM_EP];
    logic               lock_w;
    logic               ovwr_w;
    logic [EP_IDXW-1:0] sel_q;
    logic               rd_valid_q;
    logic [7:0]         rd_data_q;
    logic               val_q;
    logic               clr_q;
    logic               ctl_blocked;

    usbep_cmd_dec #(.NUM_EP(NUM_EP)) u_dec (
        .valid_i (cmd_valid),
        .byte_i  (cmd_byte),
        .cmd_o   (cmd)
    );

    usbep_stat_file #(.NUM_EP(NUM_EP)) u_stat (
        .clk         (clk),
        .rst         (rst),
        .evt_valid_i (evt_valid),
        .evt_ep_i    (evt_ep),
        .evt_err_i   (evt_err),
        .evt_ok_i    (evt_ok),
        .evt_pid1_i  (evt_pid1),
        .rd_hit_i    (cmd.kind == CK_RDSTAT),
        .rd_ep_i     (cmd.ep),
        .stat_o      (stat_w)
    );

    usbep_setup_lock u_lock (
        .clk          (clk),
        .rst          (rst),
        .setup_rx_i   (setup_rx),
        .setup_done_i (setup_done),
        .stall_i      (ctl_stall),
        .ack_i        (cmd.kind == CK_ACK),
        .flag_rd_i    (cmd.kind == CK_RDSETUP),
        .lock_o       (lock_w),
        .ovwr_o       (ovwr_w)
    );

    assign ctl_blocked = lock_w && (int'(sel_q) < CTRL_EPS);

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q      <= '0;
            rd_valid_q <= 1'b0;
            rd_data_q  <= '0;
            val_q      <= 1'b0;
            clr_q      <= 1'b0;
        end else begin
            rd_valid_q <= 1'b0;
            val_q      <= 1'b0;
            clr_q      <= 1'b0;
            case (cmd.kind)
                CK_SELECT:   sel_q <= cmd.ep;
                CK_RDSTAT: begin
                    rd_valid_q <= 1'b1;
                    rd_data_q  <= stat_to_byte(stat_w[cmd.ep]);
                end
                CK_RDSETUP: begin
                    rd_valid_q <= 1'b1;
                    rd_data_q  <= setup_to_byte(ovwr_w, lock_w);
                end
                CK_VALIDATE: val_q <= !ctl_blocked;
                CK_CLEAR:    clr_q <= !ctl_blocked;
                default: ;
            endcase
        end
    end

    assign rd_valid     = rd_valid_q;
    assign rd_data      = rd_data_q;
    assign buf_validate = val_q;
    assign buf_clear    = clr_q;
    assign buf_ep       = 4'(sel_q);
    assign setup_locked = lock_w;

    AST_CTL_BLOCK: assert property (@(posedge clk) disable iff (rst)
        cmd_valid && (cmd_byte == OP_VALID || cmd_byte == OP_CLEAR)
        && setup_locked && buf_ep < 4'd2 |=> !buf_validate && !buf_clear); // R6
    AST_UNKNOWN_QUIET: assert property (@(posedge clk) disable iff (rst)
        cmd_valid && cmd_byte == 8'h55 |=> !rd_valid && !buf_validate && !buf_clear); // R10
    AST_ACK_NO_DATA: assert property (@(posedge clk) disable iff (rst)
        cmd_valid && cmd_byte == OP_ACK |=> !rd_valid); // R7
    AST_RD_PULSE: assert property (@(posedge clk) disable iff (rst)
        cmd_valid && cmd_byte[7:4] == OPH_RDSTAT |=> rd_valid); // R2

endmodule

// File: tb/usbep_status_top_tb.sv
module usbep_status_top_tb;

    logic       clk = 1'b0;
    logic       rst;
    logic       cmd_valid;
    logic [7:0] cmd_byte;
    logic       rd_valid;
    logic [7:0] rd_data;
    logic       evt_valid;
    logic [3:0] evt_ep;
    logic [3:0] evt_err;
    logic       evt_ok;
    logic       evt_pid1;
    logic       setup_rx;
    logic       setup_done;
    logic       ctl_stall;
    logic       buf_validate;
    logic       buf_clear;
    logic [3:0] buf_ep;
    logic       setup_locked;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    usbep_status_top u_dut (
        .clk          (clk),
        .rst          (rst),
        .cmd_valid    (cmd_valid),
        .cmd_byte     (cmd_byte),
        .rd_valid     (rd_valid),
        .rd_data      (rd_data),
        .evt_valid    (evt_valid),
        .evt_ep       (evt_ep),
        .evt_err      (evt_err),
        .evt_ok       (evt_ok),
        .evt_pid1     (evt_pid1),
        .setup_rx     (setup_rx),
        .setup_done   (setup_done),
        .ctl_stall    (ctl_stall),
        .buf_validate (buf_validate),
        .buf_clear    (buf_clear),
        .buf_ep       (buf_ep),
        .setup_locked (setup_locked)
    );

    // vector: {op(1=read,0=event), ep[3:0], err[3:0], ok, pid1, expected byte}
    localparam int NVEC = 12;
    localparam logic [18:0] VEC [NVEC] = '{
        {1'b0, 4'd3,  4'd0,  1'b1, 1'b1, 8'h00},
        {1'b1, 4'd3,  4'd0,  1'b0, 1'b0, 8'h41},
        {1'b1, 4'd3,  4'd0,  1'b0, 1'b0, 8'h40},
        {1'b0, 4'd5,  4'd5,  1'b0, 1'b1, 8'h00},
        {1'b1, 4'd5,  4'd0,  1'b0, 1'b0, 8'h0A},
        {1'b0, 4'd5,  4'd0,  1'b1, 1'b0, 8'h00},
        {1'b0, 4'd5,  4'd0,  1'b1, 1'b0, 8'h00},
        {1'b1, 4'd5,  4'd0,  1'b0, 1'b0, 8'h81},
        {1'b1, 4'd5,  4'd0,  1'b0, 1'b0, 8'h00},
        {1'b0, 4'd15, 4'd15, 1'b0, 1'b0, 8'h00},
        {1'b1, 4'd15, 4'd0,  1'b0, 1'b0, 8'h1E},
        {1'b1, 4'd1,  4'd0,  1'b0, 1'b0, 8'h00}
    };

    logic [18:0] v;

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic cmd(logic [7:0] b);
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_byte  = b;
        @(negedge clk);
        cmd_valid = 1'b0;
        cmd_byte  = 8'h00;
    endtask

    task automatic event_pulse(logic [3:0] ep, logic [3:0] err, logic ok, logic pid1);
        @(negedge clk);
        evt_valid = 1'b1;
        evt_ep    = ep;
        evt_err   = err;
        evt_ok    = ok;
        evt_pid1  = pid1;
        @(negedge clk);
        evt_valid = 1'b0;
    endtask

    task automatic pulse_setup();
        @(negedge clk);
        setup_rx = 1'b1;
        @(negedge clk);
        setup_rx = 1'b0;
    endtask

    task automatic pulse_done();
        @(negedge clk);
        setup_done = 1'b1;
        @(negedge clk);
        setup_done = 1'b0;
    endtask

    task automatic read_ep(string req, logic [3:0] ep, logic [7:0] exp);
        cmd(8'hA0 | {4'h0, ep});
        check({req, " rd_valid"}, {7'd0, rd_valid}, 8'h01);
        check(req, rd_data, exp);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finish");
            finish_run();
        end
    end

    initial begin
        rst = 1'b1; cmd_valid = 1'b0; cmd_byte = 8'h00;
        evt_valid = 1'b0; evt_ep = 4'h0; evt_err = 4'h0; evt_ok = 1'b0; evt_pid1 = 1'b0;
        setup_rx = 1'b0; setup_done = 1'b0; ctl_stall = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        check("R1 rd_valid", {7'd0, rd_valid}, 8'h00);
        check("R1 lock", {7'd0, setup_locked}, 8'h00);
        check("R1 buf pulses", {6'd0, buf_validate, buf_clear}, 8'h00);
        check("R1 buf_ep", {4'd0, buf_ep}, 8'h00);
        read_ep("R1 ep7 status", 4'd7, 8'h00);
        cmd(8'hD0);
        check("R1 setup flags", rd_data, 8'h00);

        // table walk: R2 R3 R4
        for (int i = 0; i < NVEC; i++) begin
            v = VEC[i];
            if (v[18]) read_ep("R2/R3/R4 vector", v[17:14], v[7:0]);
            else       event_pulse(v[17:14], v[13:10], v[9], v[8]);
        end
        @(negedge clk);
        check("R2 single pulse", {7'd0, rd_valid}, 8'h00);

        // R5 collision: event and read same ep same cycle
        event_pulse(4'd6, 4'd0, 1'b1, 1'b0);
        @(negedge clk);
        evt_valid = 1'b1; evt_ep = 4'd6; evt_err = 4'd2; evt_ok = 1'b0; evt_pid1 = 1'b1;
        cmd_valid = 1'b1; cmd_byte = 8'hA6;
        @(negedge clk);
        evt_valid = 1'b0; cmd_valid = 1'b0; cmd_byte = 8'h00;
        check("R5 old byte presented", rd_data, 8'h01);
        read_ep("R5 event wins", 4'd6, 8'h84);

        // R11 select and buffer commands
        cmd(8'h04);
        check("R11 buf_ep", {4'd0, buf_ep}, 8'h04);
        cmd(8'hFA);
        check("R11 validate ep4", {6'd0, buf_validate, buf_clear}, 8'h02);
        cmd(8'hF2);
        check("R11 clear ep4", {6'd0, buf_validate, buf_clear}, 8'h01);

        // R6 lockout
        pulse_setup();
        check("R6 locked", {7'd0, setup_locked}, 8'h01);
        cmd(8'h00);
        cmd(8'hFA);
        check("R6 ep0 validate blocked", {6'd0, buf_validate, buf_clear}, 8'h00);
        cmd(8'h01);
        cmd(8'hF2);
        check("R6 ep1 clear blocked", {6'd0, buf_validate, buf_clear}, 8'h00);
        cmd(8'h02);
        cmd(8'hFA);
        check("R6 ep2 validate passes", {6'd0, buf_validate, buf_clear}, 8'h02);

        // R10 unknown command while locked
        cmd(8'h55);
        check("R10 no pulse", {5'd0, rd_valid, buf_validate, buf_clear}, 8'h00);
        check("R10 lock kept", {7'd0, setup_locked}, 8'h01);
        check("R10 selection kept", {4'd0, buf_ep}, 8'h02);
        read_ep("R10 ep3 status kept", 4'd3, 8'h40);

        // R7 acknowledge
        pulse_done();
        cmd(8'hF4);
        check("R7 no rd_valid", {7'd0, rd_valid}, 8'h00);
        check("R7 unlocked", {7'd0, setup_locked}, 8'h00);
        cmd(8'h00);
        cmd(8'hFA);
        check("R7 ep0 validate after ack", {6'd0, buf_validate, buf_clear}, 8'h02);

        // R8 R9 overwrite
        pulse_setup();
        pulse_setup();
        cmd(8'hD0);
        check("R8 overwrite set", rd_data, 8'h09);
        cmd(8'hD0);
        check("R9 kept while busy", rd_data, 8'h09);
        pulse_done();
        cmd(8'hD0);
        check("R9 read after done", rd_data, 8'h09);
        cmd(8'hD0);
        check("R9 cleared", rd_data, 8'h01);
        cmd(8'hF4);

        // R8 stall suppresses overwrite
        pulse_setup();
        @(negedge clk);
        ctl_stall = 1'b1;
        @(negedge clk);
        ctl_stall = 1'b0;
        pulse_setup();
        cmd(8'hD0);
        check("R8 no overwrite after stall", rd_data, 8'h01);
        pulse_done();
        cmd(8'hF4);
        check("R7 final unlock", {7'd0, setup_locked}, 8'h00);

        done = 1'b1;
        finish_run();
    end

endmodule